// File: doc/BRIEF.md
# Multiplexed LCD Common Row Scan Sequencer

This block drives the common (row) side of a multiplexed dot-matrix LCD. It does not switch voltages. It produces a two-bit level-select code for each of up to 65 rows, and an external analog stage turns each code into a drive voltage.

A single select token walks down a 65-stage register. A frame-start pulse loads the token into the first row and inverts the frame polarity. Each row-step pulse then moves the token down by one row. A two-bit duty setting decides how many rows take part in the scan: 17, 33, 49 or 65. Once the token passes the last active row, it disappears until the next frame start.

Each row's code is formed from its token bit and the current polarity. A display-enable register, written through a small write port, overrides every row with the idle code while the display is off. The display is off after reset.

Top module: `rowscan_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), the token is cleared, polarity is set to 0 and the display is turned off. On the clock edge after reset, every row code is 01.
- R2: A `frame_start` pulse puts the token in row 0 and inverts the polarity. Because polarity starts at 0, the first frame after reset runs with polarity 1.
- R3: A `row_step` pulse without `frame_start` moves the token from row k to row k+1. With neither pulse, the token holds its position.
- R4: When `frame_start` and `row_step` arrive in the same cycle, `frame_start` wins and the token lands in row 0.
- R5: `duty_sel` values 0, 1, 2 and 3 give 17, 33, 49 and 65 active rows. A step from the last active row leaves no row selected until the next `frame_start`.
- R6: Rows at or beyond the active count are never selected. They always show the unselected code for the current polarity.
- R7: Row r's code sits in `row_code[2r+1:2r]`. A selected row shows 00 under polarity 0 and 11 under polarity 1. An unselected row shows 01 under polarity 0 and 10 under polarity 1.
- R8: A `disp_wr` pulse loads `disp_val` into the display enable (1 = on). While the display is off, every row shows 01 and no row is selected. Scanning carries on underneath, so the token position is correct again as soon as the display comes back on.
- R9: The row codes are registered. A pulse sampled at clock edge E shows up in `row_code` after edge E+1.
- R10: At most one row is selected at any time. While the token is inside the active rows and the display is on, exactly one row is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame-start pulse: reload the token, invert the polarity |
| row_step | input | 1 | Row-period pulse: advance the token |
| duty_sel | input | 2 | Active row count select (17/33/49/65) |
| disp_wr | input | 1 | Write strobe for the display enable |
| disp_val | input | 1 | Display enable value (1 = on) |
| row_code | output | 2*NROWS | Per-row level-select codes, row r at bits 2r+1:2r |

## Verification
Every duty setting is swept with a full frame of row steps. Each sweep runs two steps past the end of the register, which separates the correct cut-off at 17, 33, 49 or 65 rows from an off-by-one or a wrap-around. Frames alternate polarity, so all four codes appear on both selected and unselected rows. A frame run with the display off, followed by switching it back on mid-frame, separates a true output override from a stalled scan. A cycle that raises both pulses at once separates load priority from shift priority.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;
  localparam logic [1:0] LVL_IDLE = 2'b01;

  // Level code: selected -> {pol,pol}, unselected -> {pol,~pol}
  function automatic logic [1:0] lvl_code(input logic sel, input logic pol);
    return sel ? {pol, pol} : {pol, ~pol};
  endfunction
endpackage

// File: rtl/rowscan_token.sv
module rowscan_token #(
  parameter int NROWS = 65,
  parameter int STEP  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             row_step,
  input  logic [1:0]       duty_sel,
  output logic [NROWS-1:0] tok
);
  localparam int CW = $clog2(NROWS + 2);

  logic [CW-1:0]    active_cnt;
  logic [NROWS-1:0] mask;
  logic [NROWS-1:0] nxt;

  always_comb begin
    active_cnt = CW'(STEP * (int'(duty_sel) + 1) + 1);
  end

  for (genvar g = 0; g < NROWS; g++) begin : g_mask
    assign mask[g] = (CW'(g) < active_cnt);
  end

  always_comb begin
    if (frame_start)   nxt = NROWS'(1);
    else if (row_step) nxt = {tok[NROWS-2:0], 1'b0};
    else               nxt = tok;
  end

  always_ff @(posedge clk) begin
    if (rst) tok <= '0;
    else     tok <= nxt & mask;
  end
endmodule

// File: rtl/rowscan_ctrl.sv
module rowscan_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic disp_wr,
  input  logic disp_val,
  output logic pol,
  output logic disp_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pol     <= 1'b0;
      disp_on <= 1'b0;
    end else begin
      if (frame_start) pol     <= ~pol;
      if (disp_wr)     disp_on <= disp_val;
    end
  end
endmodule

// File: rtl/rowscan_encode.sv
module rowscan_encode
  import rowscan_pkg::*;
#(
  parameter int NROWS = 65
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NROWS-1:0]   tok,
  input  logic               pol,
  input  logic               disp_on,
  output logic [2*NROWS-1:0] row_code
);
  for (genvar g = 0; g < NROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)          row_code[2*g +: 2] <= LVL_IDLE;
      else if (disp_on) row_code[2*g +: 2] <= lvl_code(tok[g], pol);
      else              row_code[2*g +: 2] <= LVL_IDLE;
    end
  end
endmodule

// File: rtl/rowscan_top.sv
module rowscan_top #(
  parameter int NROWS = 65,
  parameter int STEP  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               row_step,
  input  logic [1:0]         duty_sel,
  input  logic               disp_wr,
  input  logic               disp_val,
  output logic [2*NROWS-1:0] row_code
);
  logic [NROWS-1:0] tok_w;
  logic             pol_w;
  logic             on_w;

  rowscan_token #(.NROWS(NROWS), .STEP(STEP)) u_tok (
    .clk(clk), .rst(rst), .frame_start(frame_start), .row_step(row_step),
    .duty_sel(duty_sel), .tok(tok_w)
  );

  rowscan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .disp_wr(disp_wr),
    .disp_val(disp_val), .pol(pol_w), .disp_on(on_w)
  );

  rowscan_encode #(.NROWS(NROWS)) u_enc (
    .clk(clk), .rst(rst), .tok(tok_w), .pol(pol_w), .disp_on(on_w),
    .row_code(row_code)
  );
endmodule

// File: rtl/rowscan_chk.sv
module rowscan_chk #(
  parameter int NROWS = 65,
  parameter int STEP  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               row_step,
  input logic [1:0]         duty_sel,
  input logic [NROWS-1:0]   tok,
  input logic               pol,
  input logic               disp_on,
  input logic [2*NROWS-1:0] row_code
);
  assert_tok_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok));

  assert_load_row0_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> tok[0]);

  assert_pol_flip_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (pol != $past(pol)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !row_step && $stable(duty_sel)) |=> $stable(tok));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (row_step && !frame_start && tok[0] && $stable(duty_sel)) |=> tok[1]);

  assert_tail_R6: assert property (@(posedge clk) disable iff (rst)
    (duty_sel == 2'd0 && $stable(duty_sel)) |-> (tok[NROWS-1:STEP+1] == '0));

  assert_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> (row_code == {NROWS{2'b01}}));
endmodule

bind rowscan_top rowscan_chk #(.NROWS(NROWS), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .row_step(row_step),
  .duty_sel(duty_sel), .tok(tok_w), .pol(pol_w), .disp_on(on_w),
  .row_code(row_code)
);

// File: tb/sim_rowscan_top.sv
module sim_rowscan_top;
  localparam int NROWS = 65;
  localparam int STEP  = 16;

  logic clk = 1'b0;
  logic rst, frame_start, row_step, disp_wr, disp_val;
  logic [1:0] duty_sel;
  logic [2*NROWS-1:0] row_code;

  int errors = 0;
  int checks = 0;

  // bench model
  int m_tok = -1;
  logic m_pol = 1'b0;
  logic m_on = 1'b0;

  always #2.5 clk = ~clk;

  rowscan_top #(.NROWS(NROWS), .STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .row_step(row_step),
    .duty_sel(duty_sel), .disp_wr(disp_wr), .disp_val(disp_val),
    .row_code(row_code)
  );

  function automatic int active_rows(input logic [1:0] d);
    return STEP * (int'(d) + 1) + 1;
  endfunction

  function automatic logic [2*NROWS-1:0] exp_vec();
    logic [2*NROWS-1:0] v;
    for (int r = 0; r < NROWS; r++) begin
      if (!m_on)            v[2*r +: 2] = 2'b01;
      else if (r == m_tok)  v[2*r +: 2] = {m_pol, m_pol};
      else                  v[2*r +: 2] = {m_pol, ~m_pol};
    end
    return v;
  endfunction

  function automatic int count_sel(input logic [2*NROWS-1:0] v);
    int n = 0;
    for (int r = 0; r < NROWS; r++)
      if (v[2*r +: 2] == 2'b00 || v[2*r +: 2] == 2'b11) n++;
    return n;
  endfunction

  task automatic check_vec(input string req);
    logic [2*NROWS-1:0] e;
    e = exp_vec();
    checks++;
    if (row_code !== e) begin
      errors++;
      $display("FAIL %s: row_code=%h expected=%h", req, row_code, e);
    end
  endtask

  task automatic check_count(input string req);
    int exp_n;
    int got;
    exp_n = (m_on && m_tok >= 0) ? 1 : 0;
    got = count_sel(row_code);
    checks++;
    if (got != exp_n) begin
      errors++;
      $display("FAIL %s: selected rows=%0d expected=%0d", req, got, exp_n);
    end
  endtask

  // Starts at a negedge; ends at the negedge after the output register updates.
  task automatic apply(input logic fs, input logic rs, input logic dw, input logic dv);
    frame_start = fs; row_step = rs; disp_wr = dw; disp_val = dv;
    @(negedge clk);
    frame_start = 0; row_step = 0; disp_wr = 0; disp_val = 0;
    if (fs) begin
      m_tok = 0;
      m_pol = ~m_pol;
    end else if (rs && m_tok >= 0) begin
      m_tok = m_tok + 1;
    end
    if (m_tok >= active_rows(duty_sel)) m_tok = -1;
    if (dw) m_on = dv;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; frame_start = 0; row_step = 0; disp_wr = 0; disp_val = 0; duty_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_vec("R1 reset idle");

    // R8: display still off after a frame start; no row selected
    apply(1, 0, 0, 0);
    check_vec("R8 off at frame start");
    check_count("R8 none selected while off");

    // turn the display on; the token is still at row 0 (polarity 1)
    apply(0, 0, 1, 1);
    check_vec("R8 display on");
    apply(0, 0, 0, 0);
    check_vec("R3 hold without pulses");

    // R5/R6/R7/R10: sweep every duty over a full frame plus overrun
    for (int d = 0; d < 4; d++) begin
      duty_sel = 2'(d);
      apply(1, 0, 0, 0);
      check_vec("R2 frame load");
      check_count("R10 one row");
      for (int k = 0; k < NROWS + 2; k++) begin
        apply(0, 1, 0, 0);
        check_vec("R5 R6 R7 scan step");
        check_count("R10 one row");
      end
    end

    // R4: both pulses together -> row 0
    duty_sel = 2'd3;
    apply(1, 0, 0, 0);
    apply(0, 1, 0, 0);
    apply(0, 1, 0, 0);
    apply(1, 1, 0, 0);
    check_vec("R4 load priority");

    // R8: display off mid-frame, scan continues, back on shows moved token
    apply(0, 1, 0, 0);
    apply(0, 0, 1, 0);
    check_vec("R8 forced idle");
    for (int k = 0; k < 5; k++) begin
      apply(0, 1, 0, 0);
      check_vec("R8 idle while scanning");
      check_count("R8 none selected while off");
    end
    apply(0, 0, 1, 1);
    check_vec("R8 resumes at scanned row");
    check_count("R10 one row after resume");

    // R9: output lags state by one edge
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    checks++;
    if (row_code[1:0] === {~m_pol, ~m_pol}) begin
      errors++;
      $display("FAIL R9: row0 changed early actual=%b expected=old code", row_code[1:0]);
    end
    m_tok = 0; m_pol = ~m_pol;
    @(negedge clk);
    check_vec("R9 registered output");

    // R1: reset mid-frame
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_tok = -1; m_pol = 0; m_on = 0;
    @(negedge clk);
    check_vec("R1 reset mid-frame");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule